// File: doc/BRIEF.md
# Command Queue with Transfer Pointer

This block holds a small ring of command words. A host writes them in through a push port that carries a data word and byte-lane enables. A downstream transfer engine takes them out one at a time. The oldest stored command is always shown on `cmd_out`. The engine pulses `xfer_done` once it has finished moving that command. That pulse retires the command, lowers the occupancy count and moves the read-side pointer forward.

Software can see two read-only values: the occupancy count and the index of the next slot to be transferred. The read-side index moves only when a transfer completes, and it wraps from the last slot back to slot 0. If the engine asks for a command while the queue is empty, a sticky underflow flag is set. Software clears that flag by writing a one to bit 0 of the status write port. When its enable input is high, the flag also drives an interrupt line.

Top module: `cmd_fifo_xp`

## Requirements
- R1: After reset, the count, the next-transfer index, the underflow flag, the interrupt and `cmd_valid` are all 0.
- R2: Each accepted push adds exactly one to the count, whatever pattern `push_be` has. The stored word takes `push_data` in every byte lane whose enable bit is set (bit k covers bits 8k+7..8k) and holds zero in every other lane.
- R3: A `xfer_done` pulse while the count is nonzero lowers the count by one. A `xfer_done` pulse while the count is zero changes neither the count nor the index.
- R4: Index value 0 selects the lowest storage slot, which is the slot written first after reset. The index steps by one and goes from DEPTH-1 back to 0.
- R5: The next-transfer index changes only in a cycle that has a completed transfer. Pushes, status writes and requests leave it unchanged.
- R6: A status write affects only the underflow flag. A 1 in bit 0 clears the flag, and a 0 in bit 0 leaves it as it is. All other bits, including any value aimed at the count or index, have no effect.
- R7: `xfer_req` while the count is zero sets the underflow flag on the next edge. In the same cycle, setting takes priority over a clear.
- R8: `uflow_irq` is high exactly when the flag is set and `uflow_ie` is high.
- R9: A push into a full queue, with no completion in the same cycle, is dropped. The count and the stored contents stay as they were.
- R10: A push and a completion in the same cycle with a nonzero count leave the count unchanged. This includes the full case, where the push is accepted into the slot that the completion frees.
- R11: Commands come out in push order, and `cmd_valid` is high exactly when the count is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| push_we | input | 1 | Push write strobe |
| push_be | input | 4 | Byte-lane enables of the push write |
| push_data | input | 32 | Push write data |
| xfer_req | input | 1 | Engine asks for a command |
| xfer_done | input | 1 | Engine has completed transferring the head command |
| cmd_out | output | 32 | Head command word |
| cmd_valid | output | 1 | Queue holds at least one command |
| entry_cnt | output | 4 | Read-only occupancy count |
| next_ptr | output | 2 | Read-only index of the next slot to transfer |
| sts_we | input | 1 | Status register write strobe |
| sts_wdata | input | 32 | Status write data; only bit 0 acts (write one to clear) |
| uflow_ie | input | 1 | Underflow interrupt enable |
| uflow_flag | output | 1 | Sticky underflow flag |
| uflow_irq | output | 1 | Underflow interrupt request |

## Verification
Suppose the count went wrong, for example through a dropped push that still counted or a double decrement. `entry_cnt` would then differ from the scoreboard depth on the very next sample. `cmd_valid` would disagree at the head later, when the queue drains. A corrupted write or read index stays hidden until that slot reaches the head, up to DEPTH transfers later, where `cmd_out` no longer matches the scoreboard. That is why the bench runs the index through more than one wrap. A lane-masking fault shows up only in the cycle where the partially written word is transferred.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

  // Occupancy update chosen per cycle: {push accepted, pop accepted}.
  typedef enum logic [1:0] {
    CQ_HOLD = 2'b00,
    CQ_POP  = 2'b01,
    CQ_PUSH = 2'b10,
    CQ_SWAP = 2'b11
  } cq_op_e;

endpackage

// File: rtl/cmdq_wrap_ptr.sv
// Ring index that moves by one on an enable and wraps at DEPTH-1.
module cmdq_wrap_ptr #(
  parameter int DEPTH = 4,
  parameter int PTR_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr
);

  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] ptr_nxt;

  always_comb begin
    ptr_nxt = ptr;
    if (adv) begin
      if (ptr == LAST_IDX) ptr_nxt = '0;
      else                 ptr_nxt = ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= ptr_nxt;
  end

endmodule

// File: rtl/cmdq_store.sv
// Slot storage: written with lane masking, read asynchronously by index.
module cmdq_store #(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 32,
  parameter int PTR_W  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [PTR_W-1:0]      wr_ptr,
  input  logic [DATA_W/8-1:0]   wr_be,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [PTR_W-1:0]      rd_ptr,
  output logic [DATA_W-1:0]     rd_data
);

  localparam int LANES = DATA_W / 8;

  logic [DATA_W-1:0] masked_word;
  logic [DATA_W-1:0] slot_q [DEPTH];
  logic [DEPTH-1:0]  slot_we;

  // Lanes that are not enabled are stored as zero.
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign masked_word[l*8 +: 8] = wr_be[l] ? wr_data[l*8 +: 8] : 8'h00;
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    assign slot_we[e] = wr_en && (wr_ptr == PTR_W'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          slot_q[e] <= '0;
      else if (slot_we[e]) slot_q[e] <= masked_word;
    end
  end

  assign rd_data = slot_q[rd_ptr];

endmodule

// File: rtl/cmdq_ctrl.sv
// Occupancy counter, accept decisions and the sticky underflow flag.
module cmdq_ctrl
  import cmdq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_req,
  input  logic             done_req,
  input  logic             xfer_req,
  input  logic             flag_clr,
  output logic             push_ok,
  output logic             pop_ok,
  output logic [CNT_W-1:0] cnt,
  output logic             empty,
  output logic             uflow
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic             full;
  cq_op_e           op;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;
  logic             uflow_nxt;
  logic             uflow_en;

  assign empty = (cnt == '0);
  assign full  = (cnt == FULL_CNT);

  // A completion frees a slot in the same cycle, so a push alongside it
  // is accepted even when every slot is in use.
  assign pop_ok  = done_req && !empty;
  assign push_ok = push_req && (!full || pop_ok);

  always_comb begin
    op      = cq_op_e'({push_ok, pop_ok});
    cnt_nxt = cnt;
    unique case (op)
      CQ_PUSH: cnt_nxt = cnt + 1'b1;
      CQ_POP:  cnt_nxt = cnt - 1'b1;
      default: cnt_nxt = cnt;
    endcase
  end

  assign cnt_en = (op == CQ_PUSH) || (op == CQ_POP);

  always_comb begin
    uflow_nxt = uflow;
    if (xfer_req && empty) uflow_nxt = 1'b1;
    else if (flag_clr)     uflow_nxt = 1'b0;
  end

  assign uflow_en = (xfer_req && empty) || flag_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        uflow <= 1'b0;
    else if (uflow_en) uflow <= uflow_nxt;
  end

endmodule

// File: rtl/cmd_fifo_xp.sv
module cmd_fifo_xp #(
  parameter  int DEPTH  = 4,
  parameter  int DATA_W = 32,
  parameter  int CNT_W  = 4,
  localparam int PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_we,
  input  logic [LANES-1:0]  push_be,
  input  logic [DATA_W-1:0] push_data,
  input  logic              xfer_req,
  input  logic              xfer_done,
  output logic [DATA_W-1:0] cmd_out,
  output logic              cmd_valid,
  output logic [CNT_W-1:0]  entry_cnt,
  output logic [PTR_W-1:0]  next_ptr,
  input  logic              sts_we,
  input  logic [DATA_W-1:0] sts_wdata,
  input  logic              uflow_ie,
  output logic              uflow_flag,
  output logic              uflow_irq
);

  logic             push_ok;
  logic             pop_ok;
  logic             q_empty;
  logic             flag_clr;
  logic [PTR_W-1:0] wr_ptr;
  logic             unused_sts_bits;

  // Only bit 0 of a status write acts; count and index are read-only.
  assign flag_clr        = sts_we && sts_wdata[0];
  assign unused_sts_bits = ^sts_wdata[DATA_W-1:1];

  cmdq_ctrl #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .push_req (push_we),
    .done_req (xfer_done),
    .xfer_req (xfer_req),
    .flag_clr (flag_clr),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok),
    .cnt      (entry_cnt),
    .empty    (q_empty),
    .uflow    (uflow_flag)
  );

  cmdq_wrap_ptr #(
    .DEPTH (DEPTH),
    .PTR_W (PTR_W)
  ) u_wr_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (push_ok),
    .ptr   (wr_ptr)
  );

  cmdq_wrap_ptr #(
    .DEPTH (DEPTH),
    .PTR_W (PTR_W)
  ) u_xfer_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (pop_ok),
    .ptr   (next_ptr)
  );

  cmdq_store #(
    .DEPTH  (DEPTH),
    .DATA_W (DATA_W),
    .PTR_W  (PTR_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (push_ok),
    .wr_ptr  (wr_ptr),
    .wr_be   (push_be),
    .wr_data (push_data),
    .rd_ptr  (next_ptr),
    .rd_data (cmd_out)
  );

  assign cmd_valid = !q_empty;
  assign uflow_irq = uflow_flag && uflow_ie;

endmodule

// File: rtl/cmd_fifo_xp_chk.sv
module cmd_fifo_xp_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = 4,
  parameter int PTR_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_we,
  input logic             xfer_req,
  input logic             xfer_done,
  input logic             sts_we,
  input logic             sts_clr,
  input logic             uflow_flag,
  input logic [CNT_W-1:0] entry_cnt,
  input logic [PTR_W-1:0] next_ptr
);

  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);

  a_r2_push_inc: assert property (@(posedge clk) disable iff (!rst_n)
    push_we && !xfer_done && entry_cnt != FULL_C |=> entry_cnt == $past(entry_cnt) + ONE_C);

  a_r3_done_dec: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && !push_we && entry_cnt != '0 |=> entry_cnt == $past(entry_cnt) - ONE_C);

  a_r4_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && entry_cnt != '0 && next_ptr == LAST_P |=> next_ptr == '0);

  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_done && entry_cnt != '0) |=> $stable(next_ptr));

  a_r6_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
    sts_we && sts_clr && !(xfer_req && entry_cnt == '0) |=> !uflow_flag);

  a_r7_uflow_set: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req && entry_cnt == '0 |=> uflow_flag);

  a_r9_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
    push_we && !xfer_done && entry_cnt == FULL_C |=> entry_cnt == FULL_C);

  a_r10_swap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    push_we && xfer_done && entry_cnt != '0 |=> $stable(entry_cnt));

  a_r11_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    entry_cnt <= FULL_C);

endmodule

bind cmd_fifo_xp cmd_fifo_xp_chk #(
  .DEPTH (DEPTH),
  .CNT_W (CNT_W),
  .PTR_W (PTR_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .push_we    (push_we),
  .xfer_req   (xfer_req),
  .xfer_done  (xfer_done),
  .sts_we     (sts_we),
  .sts_clr    (sts_wdata[0]),
  .uflow_flag (uflow_flag),
  .entry_cnt  (entry_cnt),
  .next_ptr   (next_ptr)
);

// File: tb/cmd_fifo_xp_tb_top.sv
module cmd_fifo_xp_tb_top;

  localparam int DEPTH  = 4;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 4;
  localparam int PTR_W  = 2;
  localparam time CLK_P = 20ns;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              push_we = 1'b0;
  logic [3:0]        push_be = '0;
  logic [DATA_W-1:0] push_data = '0;
  logic              xfer_req = 1'b0;
  logic              xfer_done = 1'b0;
  logic [DATA_W-1:0] cmd_out;
  logic              cmd_valid;
  logic [CNT_W-1:0]  entry_cnt;
  logic [PTR_W-1:0]  next_ptr;
  logic              sts_we = 1'b0;
  logic [DATA_W-1:0] sts_wdata = '0;
  logic              uflow_ie = 1'b0;
  logic              uflow_flag;
  logic              uflow_irq;

  int n_chk = 0;
  int n_err = 0;
  int m_ptr = 0;
  bit m_flag = 1'b0;
  bit running = 1'b0;
  bit finished = 1'b0;
  logic [DATA_W-1:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  cmd_fifo_xp #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .push_we(push_we), .push_be(push_be),
    .push_data(push_data), .xfer_req(xfer_req), .xfer_done(xfer_done),
    .cmd_out(cmd_out), .cmd_valid(cmd_valid), .entry_cnt(entry_cnt),
    .next_ptr(next_ptr), .sts_we(sts_we), .sts_wdata(sts_wdata),
    .uflow_ie(uflow_ie), .uflow_flag(uflow_flag), .uflow_irq(uflow_irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h @%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] lane_mask(input logic [3:0] be, input logic [31:0] d);
    logic [31:0] r;
    for (int l = 0; l < 4; l++) r[l*8 +: 8] = be[l] ? d[l*8 +: 8] : 8'h00;
    return r;
  endfunction

  // Driver: one cycle of stimulus, with the scoreboard updated for accepted pushes.
  task automatic cyc(input logic p, input logic [3:0] be, input logic [31:0] d,
                     input logic dn, input logic rq, input logic swe,
                     input logic [31:0] swd);
    int  sz;
    bit  pop_ok;
    bit  push_ok;
    @(negedge clk);
    #1;
    push_we = p; push_be = be; push_data = d;
    xfer_done = dn; xfer_req = rq; sts_we = swe; sts_wdata = swd;
    sz      = exp_q.size();
    pop_ok  = dn && (sz != 0);
    push_ok = p && ((sz < DEPTH) || pop_ok);
    if (rq && sz == 0)     m_flag = 1'b1;
    else if (swe && swd[0]) m_flag = 1'b0;
    if (pop_ok) m_ptr = (m_ptr + 1) % DEPTH;
    @(posedge clk);
    #2;
    if (push_ok) exp_q.push_back(lane_mask(be, d));
    push_we = 1'b0; xfer_done = 1'b0; xfer_req = 1'b0; sts_we = 1'b0;
  endtask

  task automatic push(input logic [3:0] be, input logic [31:0] d);
    cyc(1'b1, be, d, 1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic done1();
    cyc(1'b0, 4'h0, '0, 1'b1, 1'b0, 1'b0, '0);
  endtask

  task automatic verify(input string tag);
    chk(entry_cnt == CNT_W'(exp_q.size()), {tag, " count"}, 32'(entry_cnt), 32'(exp_q.size()));
    chk(next_ptr == PTR_W'(m_ptr), {tag, " index"}, 32'(next_ptr), 32'(m_ptr));
    chk(uflow_flag == m_flag, {tag, " flag"}, 32'(uflow_flag), 32'(m_flag));
    chk(uflow_irq == (m_flag && uflow_ie), {"R8 irq"}, 32'(uflow_irq), 32'(m_flag && uflow_ie));
  endtask

  // Monitor: compares the head word of every completed transfer (R11, R2 lanes, R4 slot 0).
  always @(negedge clk) begin
    #5;
    if (running) begin
      chk(cmd_valid == (exp_q.size() != 0), "R11 valid", 32'(cmd_valid), 32'(exp_q.size() != 0));
      if (xfer_done && cmd_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R11 extra output", cmd_out, '0);
        else begin
          chk(cmd_out == exp_q[0], "R11 order", cmd_out, exp_q[0]);
          void'(exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(CLK_P * 150000);
    chk(1'b0, "WATCHDOG", '0, '0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    chk(entry_cnt == '0, "R1 count", 32'(entry_cnt), 0);
    chk(next_ptr == '0, "R1 index", 32'(next_ptr), 0);
    chk(!uflow_flag && !uflow_irq, "R1 flag", 32'(uflow_flag), 0);
    chk(!cmd_valid, "R1 valid", 32'(cmd_valid), 0);
    @(negedge clk);
    rst_n = 1'b1;
    running = 1'b1;

    // R2: full-word pushes, then a partial lane push; R4: first word lands in slot 0
    for (int k = 0; k < 3; k++) begin
      push(4'hF, 32'hC0DE_0000 + 32'(k));
      verify("R2");
    end
    push(4'b0101, 32'hAABB_CCDD);
    verify("R2 partial");

    // R9: push into full queue dropped
    push(4'hF, 32'hDEAD_BEEF);
    verify("R9");

    // R6: status write aimed at count and index, bit 0 low
    cyc(1'b0, 4'h0, '0, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFE);
    verify("R6");

    // R3/R5: two completions
    done1(); verify("R3");
    done1(); verify("R5");

    // R10: push and completion together
    cyc(1'b1, 4'hF, 32'h1111_2222, 1'b1, 1'b0, 1'b0, '0);
    verify("R10");

    // R4: index wraps from 3 to 0
    done1(); verify("R4 wrap");

    // R5: a push alone leaves the index
    push(4'b1000, 32'h5566_7788);
    verify("R5 push");

    done1(); done1(); done1();
    verify("R3 drain");

    // R3: completion at zero ignored
    done1(); verify("R3 empty");

    // R7/R8: underflow with interrupt masked, then enabled
    cyc(1'b0, 4'h0, '0, 1'b0, 1'b1, 1'b0, '0);
    verify("R7");
    uflow_ie = 1'b1;
    #1;
    verify("R8");

    // R6: bit 0 low keeps the flag, bit 0 high clears it
    cyc(1'b0, 4'h0, '0, 1'b0, 1'b0, 1'b1, 32'h0000_0002);
    verify("R6 keep");
    cyc(1'b0, 4'h0, '0, 1'b0, 1'b0, 1'b1, 32'h0000_0001);
    verify("R6 clear");

    // R7: set wins over clear
    cyc(1'b0, 4'h0, '0, 1'b0, 1'b1, 1'b1, 32'h0000_0001);
    verify("R7 priority");
    cyc(1'b0, 4'h0, '0, 1'b0, 1'b0, 1'b1, 32'h0000_0001);
    verify("R6 clear2");

    // R10: fill, then push with completion while full
    for (int k = 0; k < 4; k++) push(4'hF, 32'hA500_0000 + 32'(k));
    verify("R9 full");
    cyc(1'b1, 4'b0011, 32'h9999_ABCD, 1'b1, 1'b0, 1'b0, '0);
    verify("R10 full");

    for (int k = 0; k < 5; k++) done1();
    verify("R11 drain");
    done1();

    running = 1'b0;
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule